// File: doc/BRIEF.md
# Wiper Position Counter with One-Hot Tap Select

This block keeps the volatile position of one digital potentiometer wiper and turns it into the select vector for the tap switches of its resistor string. The position is a small binary count, with 64 taps across 63 segments by default. The select output drives the switch row, and exactly one bit of it is high at any time. One instance serves each potentiometer.

The position changes in four ways. A power-up recall strobe copies in the value held in the first stored setting. A direct write carries a value that came over the serial path. A transfer carries a value from one of the stored settings. Single-step requests move the wiper up by one segment, toward the high terminal, or down by one segment, toward the low terminal. All strobes last one clock. When several arrive in the same clock, a fixed priority picks one of them. Steps stop at the two ends and do not wrap around. The binary position is also output so that it can be read back.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge `pos` becomes 0 and `tap_sel` becomes 64'h1, so only bit 0 is set.
- R2: After reset, `tap_sel` has exactly one bit set in every cycle.
- R3: `tap_sel` is registered. One cycle after `pos` holds value k, bit k of `tap_sel` is the only bit set.
- R4: A one-cycle `wr_stb` makes `pos` equal `wr_val` at the next clock edge.
- R5: A one-cycle `xfr_stb` makes `pos` equal `xfr_val` at the next clock edge.
- R6: A one-cycle `recall_stb` makes `pos` equal `recall_val` at the next clock edge. When load strobes coincide, the priority is `recall_stb`, then `wr_stb`, then `xfr_stb`.
- R7: With no load strobe, `step_up` alone adds 1 to `pos` (toward the high terminal) and `step_dn` alone subtracts 1 (toward the low terminal).
- R8: Steps saturate. `step_up` at 63 leaves 63, and `step_dn` at 0 leaves 0.
- R9: A load strobe in the same cycle as a step wins, and the step is dropped.
- R10: `step_up` and `step_dn` together, with no load strobe, leave `pos` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| recall_stb | input | 1 | Power-up recall strobe |
| recall_val | input | 6 | Value of stored setting 0 |
| wr_stb | input | 1 | Direct write strobe |
| wr_val | input | 6 | Direct write value |
| xfr_stb | input | 1 | Transfer-from-stored-setting strobe |
| xfr_val | input | 6 | Value of the selected stored setting |
| step_up | input | 1 | Step one segment toward the high terminal |
| step_dn | input | 1 | Step one segment toward the low terminal |
| pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | One-hot tap switch select |

## Verification
Two things can happen in the same cycle: a load and a step, or two loads. The bench drives these together in one clock. It pairs a step with a direct write, pairs a step with a transfer, and pairs all three loads at once. It checks that `pos` holds exactly the winning value and shows no ±1 step on top of it. It repeats the step collisions at both ends of the range so that the saturation logic and the priority logic meet.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    parameter int POS_W = 6;
    localparam int TAPS = 1 << POS_W;
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(TAPS - 1);

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } wiper_op_e;

    typedef struct packed {
        wiper_op_e op;
        pos_t      val;
    } wiper_cmd_t;

    function automatic pos_t step_sat(input pos_t cur, input logic up);
        if (up)
            return (cur == POS_MAX) ? cur : cur + pos_t'(1);
        else
            return (cur == '0) ? cur : cur - pos_t'(1);
    endfunction
endpackage

// File: rtl/wiper_cmd_arb.sv
module wiper_cmd_arb
    import wiper_pkg::*;
(
    input  logic       recall_stb,
    input  pos_t       recall_val,
    input  logic       wr_stb,
    input  pos_t       wr_val,
    input  logic       xfr_stb,
    input  pos_t       xfr_val,
    input  logic       step_up,
    input  logic       step_dn,
    output wiper_cmd_t cmd
);
    always_comb begin
        cmd.op  = OP_HOLD;
        cmd.val = '0;
        if (recall_stb) begin
            cmd.op  = OP_LOAD;
            cmd.val = recall_val;
        end else if (wr_stb) begin
            cmd.op  = OP_LOAD;
            cmd.val = wr_val;
        end else if (xfr_stb) begin
            cmd.op  = OP_LOAD;
            cmd.val = xfr_val;
        end else if (step_up && !step_dn) begin
            cmd.op = OP_UP;
        end else if (step_dn && !step_up) begin
            cmd.op = OP_DOWN;
        end
    end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
    import wiper_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wiper_cmd_t cmd,
    output pos_t       pos
);
    pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            unique case (cmd.op)
                OP_LOAD: pos_q <= cmd.val;
                OP_UP:   pos_q <= step_sat(pos_q, 1'b1);
                OP_DOWN: pos_q <= step_sat(pos_q, 1'b0);
                default: pos_q <= pos_q;
            endcase
        end
    end

    assign pos = pos_q;

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_HOLD) |=> $stable(pos_q));
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode
    import wiper_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pos_t            pos,
    output logic [TAPS-1:0] tap_sel
);
    logic [TAPS-1:0] tap_q;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst)
                tap_q[i] <= (i == 0);
            else
                tap_q[i] <= (pos == POS_W'(i));
        end
    end

    assign tap_sel = tap_q;

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_q) == 1);
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
    import wiper_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            recall_stb,
    input  logic [POS_W-1:0] recall_val,
    input  logic            wr_stb,
    input  logic [POS_W-1:0] wr_val,
    input  logic            xfr_stb,
    input  logic [POS_W-1:0] xfr_val,
    input  logic            step_up,
    input  logic            step_dn,
    output logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  tap_sel
);
    wiper_cmd_t cmd;

    wiper_cmd_arb u_arb (
        .recall_stb(recall_stb), .recall_val(recall_val),
        .wr_stb(wr_stb), .wr_val(wr_val),
        .xfr_stb(xfr_stb), .xfr_val(xfr_val),
        .step_up(step_up), .step_dn(step_dn),
        .cmd(cmd)
    );

    wiper_pos_reg u_pos (
        .clk(clk), .rst(rst), .cmd(cmd), .pos(pos)
    );

    wiper_tap_decode u_dec (
        .clk(clk), .rst(rst), .pos(pos), .tap_sel(tap_sel)
    );

    logic any_load;
    assign any_load = recall_stb | wr_stb | xfr_stb;

    p_tap_follow_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tap_sel[$past(pos)]);

    p_recall_r6: assert property (@(posedge clk) disable iff (rst)
        recall_stb |=> pos == $past(recall_val));

    p_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !recall_stb) |=> pos == $past(wr_val));

    p_xfr_r5: assert property (@(posedge clk) disable iff (rst)
        (xfr_stb && !wr_stb && !recall_stb) |=> pos == $past(xfr_val));

    p_sat_top_r8: assert property (@(posedge clk) disable iff (rst)
        (!any_load && step_up && pos == POS_MAX) |=> pos == POS_MAX);

    p_sat_bot_r8: assert property (@(posedge clk) disable iff (rst)
        (!any_load && step_dn && pos == '0) |=> pos == '0);

    p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
        (!any_load && step_up && !step_dn && pos != POS_MAX)
        |=> pos == $past(pos) + 1'b1);
endmodule

// File: tb/wiper_tap_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_tap_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic recall_stb = 0, wr_stb = 0, xfr_stb = 0, step_up = 0, step_dn = 0;
    logic [5:0] recall_val = '0, wr_val = '0, xfr_val = '0;
    logic [5:0] pos;
    logic [63:0] tap_sel;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wiper_tap_ctrl u_wiper_tap_ctrl (
        .clk(clk), .rst(rst),
        .recall_stb(recall_stb), .recall_val(recall_val),
        .wr_stb(wr_stb), .wr_val(wr_val),
        .xfr_stb(xfr_stb), .xfr_val(xfr_val),
        .step_up(step_up), .step_dn(step_dn),
        .pos(pos), .tap_sel(tap_sel)
    );

    task automatic chk_pos(input string req, input logic [5:0] exp);
        n_run++;
        if (pos !== exp) begin
            n_fail++;
            $display("FAIL %s pos actual=%0d expected=%0d", req, pos, exp);
        end
    endtask

    task automatic chk_tap(input string req, input logic [5:0] exp);
        logic [63:0] e;
        e = 64'h1 << exp;
        n_run++;
        if (tap_sel !== e) begin
            n_fail++;
            $display("FAIL %s tap actual=%h expected=%h", req, tap_sel, e);
        end
    endtask

    // Drive one clock of strobes starting at a falling edge; returns at the next falling edge.
    task automatic drive(input logic rc, input logic [5:0] rv, input logic w, input logic [5:0] wv,
                         input logic x, input logic [5:0] xv, input logic u, input logic d);
        recall_stb = rc; recall_val = rv; wr_stb = w; wr_val = wv;
        xfr_stb = x; xfr_val = xv; step_up = u; step_dn = d;
        @(negedge clk);
        recall_stb = 0; wr_stb = 0; xfr_stb = 0; step_up = 0; step_dn = 0;
    endtask

    task automatic t_reset;
        chk_pos("R1", 6'd0);
        chk_tap("R1", 6'd0);
    endtask

    task automatic t_loads;
        drive(1, 6'd17, 0, 0, 0, 0, 0, 0);
        chk_pos("R6", 6'd17);
        @(negedge clk); chk_tap("R3", 6'd17);
        drive(0, 0, 1, 6'd42, 0, 0, 0, 0);
        chk_pos("R4", 6'd42);
        @(negedge clk); chk_tap("R3", 6'd42);
        drive(0, 0, 0, 0, 1, 6'd5, 0, 0);
        chk_pos("R5", 6'd5);
        @(negedge clk); chk_tap("R2", 6'd5);
    endtask

    task automatic t_priority;
        drive(1, 6'd9, 1, 6'd20, 1, 6'd30, 0, 0);
        chk_pos("R6 recall over write/xfr", 6'd9);
        drive(0, 0, 1, 6'd20, 1, 6'd30, 0, 0);
        chk_pos("R6 write over xfr", 6'd20);
        drive(0, 0, 0, 0, 1, 6'd30, 1, 0);
        chk_pos("R9 xfr beats step_up", 6'd30);
        drive(0, 0, 1, 6'd0, 0, 0, 0, 1);
        chk_pos("R9 write beats step_dn", 6'd0);
    endtask

    task automatic t_steps;
        drive(0, 0, 1, 6'd10, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        chk_pos("R7 up", 6'd11);
        @(negedge clk); chk_tap("R3", 6'd11);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        chk_pos("R7 down", 6'd9);
        drive(0, 0, 0, 0, 0, 0, 1, 1);
        chk_pos("R10 both", 6'd9);
        @(negedge clk); chk_tap("R10", 6'd9);
    endtask

    task automatic t_saturate;
        drive(0, 0, 1, 6'd62, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        chk_pos("R8 reach top", 6'd63);
        drive(0, 0, 0, 0, 0, 0, 1, 0);
        chk_pos("R8 top hold", 6'd63);
        @(negedge clk); chk_tap("R8", 6'd63);
        drive(0, 0, 0, 0, 1, 6'd63, 0, 1);
        chk_pos("R9 load at top with step_dn", 6'd63);
        drive(1, 6'd0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        chk_pos("R8 bottom hold", 6'd0);
        @(negedge clk); chk_tap("R8", 6'd0);
        drive(0, 0, 1, 6'd0, 0, 0, 1, 0);
        chk_pos("R9 load at bottom with step_up", 6'd0);
    endtask

    task automatic t_rereset;
        drive(0, 0, 1, 6'd33, 0, 0, 0, 0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk_pos("R1 re-reset", 6'd0);
        chk_tap("R1 re-reset", 6'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_loads();
        t_priority();
        t_steps();
        t_saturate();
        t_rereset();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule